// File: doc/BRIEF.md
# Privileged Control Register Access Arbiter

This block owns one 64-bit feature-access control register and decides the fate of every system-register read or write aimed at it. A request arrives with the requesting privilege level (0 to 3), a flag that selects the direct encoding or the hypervisor alias encoding, a read/write flag and write data. A set of steering inputs describes the machine's state: debug halt, secure-debug disable, the presence and trap settings of levels 2 and 3, fine-grained read and write traps, host mode, the 64-bit state of level 2 and the three nested-virtualization bits.

The decision is combinational in the request cycle. There are five outcomes: a real register access, an undefined instruction, a trap to level 2 or 3, a redirect to a nested-virtualization memory slot, or a redirect to the level-2 trap register. The memory slot and the alternate register sit outside the block behind plain read-data inputs and write-enable/write-data outputs. A write to the held register commits on the next rising clock edge. Only three fields of the register can be written: a trace-trap bit at bit 28, a floating-point control pair at bits 21:20 and a vector control pair at bits 17:16. Other blocks decode these fields at these bit positions.

Top module: `pcr_access_arb`

## Requirements
- R1: Any request at level 0 (req_lvl_i=0) gives outcome_o=1 (undefined), with either encoding.
- R2: At level 1 the direct encoding (req_alias_i=0) takes the first matching rule, in this order. The first rule is undefined (1) when halted, secure debug is off, level 3 is present, the level-3 trap is set and the level-3-first option is set. The second is a trap to level 2 when level 2 is enabled and its trap is set. The third is a trap to level 2 when level 2 is enabled, level 3 is absent or its fine-grained enable is set, and the fine-grained trap for the request's direction is set. The fourth applies when level 3 is present with its trap set: it is a trap to level 3, or undefined when halted with secure debug off. After these come R3, and then a register access (0).
- R3: At level 1, the direct encoding with level 2 enabled and nest_virt_i=3'b111 gives outcome_o=3. mem_addr_o then shows offset 0x100, mem_we_o follows a write, and rdata_o returns mem_rdata_i.
- R4: At level 2, the direct encoding first applies the level-3 rules of R2. After that it gives outcome_o=4 when host_mode_i=1, where alt_we_o follows a write and rdata_o returns alt_rdata_i. Otherwise it is a register access.
- R5: At level 1, the alias encoding with level 2 enabled gives outcome 3 when nest_virt_i=3'b101. Otherwise, with level 2 enabled and nest_virt_i[0]=1, it traps to level 2. Every other case is undefined.
- R6: At level 2, the alias encoding is undefined unless host_mode_i=1. When host_mode_i=1 it applies the level-3 rules of R2 and then accesses the register.
- R7: At level 3, the alias encoding accesses the register only when level 2 is enabled, level 2 runs in 64-bit state and host_mode_i=1. Otherwise it is undefined.
- R8: At level 3, the direct encoding always accesses the register (outcome 0).
- R9: On a trap (outcome 2), trap_class_o=6'h18 and trap_lvl_o holds 2 or 3. On every other outcome both are zero.
- R10: Only bits 28, 21:20 and 17:16 store data. All other bits read as zero and ignore writes.
- R11: The register changes only on a valid write whose outcome is 0. Traps, undefined requests and redirects leave it unchanged.
- R12: rst_ni low clears the register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_lvl_i | input | 2 | Requesting privilege level |
| req_alias_i | input | 1 | 1 = hypervisor alias encoding, 0 = direct |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 64 | Write data |
| halted_i | input | 1 | Core halted in debug |
| sec_dbg_off_i | input | 1 | Secure debug disabled |
| l3_first_i | input | 1 | Level-3 trap takes priority while halted |
| l3_present_i | input | 1 | Level 3 implemented |
| l3_cap_trap_i | input | 1 | Level-3 trap on this register |
| l3_fg_en_i | input | 1 | Level 3 permits fine-grained traps |
| l2_en_i | input | 1 | Level 2 enabled |
| l2_64b_i | input | 1 | Level 2 runs in 64-bit state |
| host_mode_i | input | 1 | Level-2 host mode |
| l2_cap_trap_i | input | 1 | Level-2 trap on this register |
| fg_rd_trap_i | input | 1 | Fine-grained read trap |
| fg_wr_trap_i | input | 1 | Fine-grained write trap |
| nest_virt_i | input | 3 | Nested-virtualization bits, bit 0 the base enable |
| mem_rdata_i | input | 64 | Read data from the memory slot |
| alt_rdata_i | input | 64 | Read data from the level-2 trap register |
| rdata_o | output | 64 | Read result |
| outcome_o | output | 3 | 0 reg, 1 undefined, 2 trap, 3 memory, 4 alternate |
| trap_lvl_o | output | 2 | Trap target level |
| trap_class_o | output | 6 | Trap class code |
| mem_addr_o | output | 12 | Memory slot offset |
| mem_we_o | output | 1 | Memory slot write enable |
| mem_wdata_o | output | 64 | Memory slot write data |
| alt_we_o | output | 1 | Alternate register write enable |
| alt_wdata_o | output | 64 | Alternate register write data |

## Verification
The only state is the stored register, so a corrupted field shows up on the first register read after it, one cycle after the bad write. A wrong step in the priority chain shows in the same cycle on outcome_o, trap_lvl_o or trap_class_o. A missed write gate on a trapped or redirected request shows at the next direct read at level 3. The bench therefore reads the register back right after every write that must be dropped.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [2:0] {
    OC_REG   = 3'd0,
    OC_UNDEF = 3'd1,
    OC_TRAP  = 3'd2,
    OC_MEM   = 3'd3,
    OC_ALT   = 3'd4
  } outcome_e;

  typedef struct packed {
    logic       halted;
    logic       sec_dbg_off;
    logic       l3_first;
    logic       l3_present;
    logic       l3_cap_trap;
    logic       l3_fg_en;
    logic       l2_en;
    logic       l2_64b;
    logic       host_mode;
    logic       l2_cap_trap;
    logic       fg_rd_trap;
    logic       fg_wr_trap;
    logic [2:0] nest_virt;
  } steer_t;

  localparam logic [5:0] TRAP_CLASS = 6'h18;
  localparam logic [1:0] LVL2 = 2'd2;
  localparam logic [1:0] LVL3 = 2'd3;
endpackage

// File: rtl/pcr_decide.sv
module pcr_decide
  import pcr_pkg::*;
(
  input  logic [1:0] lvl_i,
  input  logic       alias_i,
  input  logic       wr_i,
  input  steer_t     st_i,
  output outcome_e   oc_o,
  output logic [1:0] tgt_o
);
  logic l3_undef_first, l3_trap, l3_halt_undef, fg_hit;

  always_comb begin
    l3_undef_first = st_i.halted && st_i.sec_dbg_off && st_i.l3_present &&
                     st_i.l3_first && st_i.l3_cap_trap;
    l3_trap        = st_i.l3_present && st_i.l3_cap_trap;
    l3_halt_undef  = st_i.halted && st_i.sec_dbg_off;
    fg_hit         = st_i.l2_en && (!st_i.l3_present || st_i.l3_fg_en) &&
                     (wr_i ? st_i.fg_wr_trap : st_i.fg_rd_trap);
    oc_o  = OC_UNDEF;
    tgt_o = 2'd0;
    unique case (lvl_i)
      2'd1: begin
        if (!alias_i) begin
          if (l3_undef_first)                         oc_o = OC_UNDEF;
          else if (st_i.l2_en && st_i.l2_cap_trap) begin oc_o = OC_TRAP; tgt_o = LVL2; end
          else if (fg_hit)                          begin oc_o = OC_TRAP; tgt_o = LVL2; end
          else if (l3_trap) begin
            if (l3_halt_undef) oc_o = OC_UNDEF;
            else begin oc_o = OC_TRAP; tgt_o = LVL3; end
          end
          else if (st_i.l2_en && st_i.nest_virt == 3'b111) oc_o = OC_MEM;
          else                                              oc_o = OC_REG;
        end else begin
          if (st_i.l2_en && st_i.nest_virt == 3'b101)    oc_o = OC_MEM;
          else if (st_i.l2_en && st_i.nest_virt[0]) begin oc_o = OC_TRAP; tgt_o = LVL2; end
          else                                           oc_o = OC_UNDEF;
        end
      end
      2'd2: begin
        if (alias_i && !st_i.host_mode) oc_o = OC_UNDEF;
        else if (l3_undef_first)        oc_o = OC_UNDEF;
        else if (l3_trap) begin
          if (l3_halt_undef) oc_o = OC_UNDEF;
          else begin oc_o = OC_TRAP; tgt_o = LVL3; end
        end
        else if (!alias_i && st_i.host_mode) oc_o = OC_ALT;
        else                                 oc_o = OC_REG;
      end
      2'd3: begin
        if (!alias_i) oc_o = OC_REG;
        else if (st_i.l2_en && st_i.l2_64b && st_i.host_mode) oc_o = OC_REG;
        else oc_o = OC_UNDEF;
      end
      default: oc_o = OC_UNDEF;
    endcase
  end
endmodule

// File: rtl/pcr_store.sv
module pcr_store #(
  parameter int          DATA_W  = 64,
  parameter logic [63:0] WR_MASK = 64'h0000_0000_1033_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (WR_MASK[b]) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_o[b] <= 1'b0;
        else if (we_i) q_o[b] <= wdata_i[b];
      end
    end else begin : g_zero
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/pcr_rdmux.sv
module pcr_rdmux
  import pcr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  outcome_e          oc_i,
  input  logic [DATA_W-1:0] reg_q_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] alt_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    unique case (oc_i)
      OC_REG:  rdata_o = reg_q_i;
      OC_MEM:  rdata_o = mem_i;
      OC_ALT:  rdata_o = alt_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pcr_access_arb.sv
module pcr_access_arb
  import pcr_pkg::*;
#(
  parameter int          DATA_W   = 64,
  parameter int          ADDR_W   = 12,
  parameter logic [63:0] WR_MASK  = 64'h0000_0000_1033_0000,
  parameter logic [11:0] SLOT_OFS = 12'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_lvl_i,
  input  logic              req_alias_i,
  input  logic              req_wr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              halted_i,
  input  logic              sec_dbg_off_i,
  input  logic              l3_first_i,
  input  logic              l3_present_i,
  input  logic              l3_cap_trap_i,
  input  logic              l3_fg_en_i,
  input  logic              l2_en_i,
  input  logic              l2_64b_i,
  input  logic              host_mode_i,
  input  logic              l2_cap_trap_i,
  input  logic              fg_rd_trap_i,
  input  logic              fg_wr_trap_i,
  input  logic [2:0]        nest_virt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alt_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        outcome_o,
  output logic [1:0]        trap_lvl_o,
  output logic [5:0]        trap_class_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              alt_we_o,
  output logic [DATA_W-1:0] alt_wdata_o
);
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_OFS);

  steer_t            st;
  outcome_e          oc;
  logic [1:0]        tgt;
  logic              ctl_we;
  logic [DATA_W-1:0] ctl_q;

  assign st = '{halted: halted_i, sec_dbg_off: sec_dbg_off_i, l3_first: l3_first_i,
                l3_present: l3_present_i, l3_cap_trap: l3_cap_trap_i, l3_fg_en: l3_fg_en_i,
                l2_en: l2_en_i, l2_64b: l2_64b_i, host_mode: host_mode_i,
                l2_cap_trap: l2_cap_trap_i, fg_rd_trap: fg_rd_trap_i,
                fg_wr_trap: fg_wr_trap_i, nest_virt: nest_virt_i};

  pcr_decide u_decide (
    .lvl_i  (req_lvl_i),
    .alias_i(req_alias_i),
    .wr_i   (req_wr_i),
    .st_i   (st),
    .oc_o   (oc),
    .tgt_o  (tgt)
  );

  assign ctl_we = req_valid_i && req_wr_i && (oc == OC_REG);

  pcr_store #(.DATA_W(DATA_W), .WR_MASK(WR_MASK)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_we),
    .wdata_i(req_wdata_i),
    .q_o    (ctl_q)
  );

  pcr_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .oc_i   (oc),
    .reg_q_i(ctl_q),
    .mem_i  (mem_rdata_i),
    .alt_i  (alt_rdata_i),
    .rdata_o(rdata_o)
  );

  assign outcome_o    = oc;
  assign trap_lvl_o   = (oc == OC_TRAP) ? tgt : 2'd0;
  assign trap_class_o = (oc == OC_TRAP) ? TRAP_CLASS : 6'd0;
  assign mem_addr_o   = (oc == OC_MEM) ? SLOT : '0;
  assign mem_we_o     = req_valid_i && req_wr_i && (oc == OC_MEM);
  assign mem_wdata_o  = req_wdata_i;
  assign alt_we_o     = req_valid_i && req_wr_i && (oc == OC_ALT);
  assign alt_wdata_o  = req_wdata_i;
endmodule

// File: rtl/pcr_access_arb_chk.sv
module pcr_access_arb_chk #(
  parameter int          DATA_W   = 64,
  parameter int          ADDR_W   = 12,
  parameter logic [63:0] WR_MASK  = 64'h0000_0000_1033_0000,
  parameter logic [11:0] SLOT_OFS = 12'h100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_lvl_i,
  input logic              req_alias_i,
  input logic              req_wr_i,
  input logic [2:0]        outcome_o,
  input logic [1:0]        trap_lvl_o,
  input logic [5:0]        trap_class_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] ctl_q
);
  localparam logic [DATA_W-1:0] RSVD = ~DATA_W'(WR_MASK);

  a_r1_level0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_lvl_i == 2'd0) |-> outcome_o == 3'd1);

  a_r8_direct_l3_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_lvl_i == 2'd3 && !req_alias_i) |-> outcome_o == 3'd0);

  a_r9_trap_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_o == 3'd2) |-> (trap_class_o == 6'h18 && trap_lvl_o[1]));

  a_r9_no_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_o != 3'd2) |-> (trap_class_o == 6'd0 && trap_lvl_o == 2'd0));

  a_r3_slot_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_o == 3'd3) |-> mem_addr_o == ADDR_W'(SLOT_OFS));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_wr_i && outcome_o == 3'd0) |=> $stable(ctl_q));

  a_r10_reserved_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_wr_i && outcome_o == 3'd0) |-> (rdata_o & RSVD) == '0);
endmodule

bind pcr_access_arb pcr_access_arb_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_MASK(WR_MASK), .SLOT_OFS(SLOT_OFS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_lvl_i   (req_lvl_i),
  .req_alias_i (req_alias_i),
  .req_wr_i    (req_wr_i),
  .outcome_o   (outcome_o),
  .trap_lvl_o  (trap_lvl_o),
  .trap_class_o(trap_class_o),
  .mem_addr_o  (mem_addr_o),
  .rdata_o     (rdata_o),
  .ctl_q       (ctl_q)
);

// File: tb/pcr_access_arb_tb.sv
module pcr_access_arb_tb;
  localparam logic O = 1'b0, I = 1'b1;
  localparam logic [63:0] MASK = 64'h0000_0000_1033_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid, alias_s, wr, halt, sdd, prio, l3p, l3cap, l3fg, l2en, l264, host, l2cap, fgr, fgw;
  logic [1:0]  lvl;
  logic [2:0]  nv;
  logic [63:0] wdata, mem_rd, alt_rd;
  logic [63:0] rdata, mem_wd, alt_wd;
  logic [2:0]  oc;
  logic [1:0]  tl;
  logic [5:0]  cls;
  logic [11:0] maddr;
  logic        mwe, awe;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pcr_access_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_lvl_i(lvl),
    .req_alias_i(alias_s), .req_wr_i(wr), .req_wdata_i(wdata),
    .halted_i(halt), .sec_dbg_off_i(sdd), .l3_first_i(prio), .l3_present_i(l3p),
    .l3_cap_trap_i(l3cap), .l3_fg_en_i(l3fg), .l2_en_i(l2en), .l2_64b_i(l264),
    .host_mode_i(host), .l2_cap_trap_i(l2cap), .fg_rd_trap_i(fgr), .fg_wr_trap_i(fgw),
    .nest_virt_i(nv), .mem_rdata_i(mem_rd), .alt_rdata_i(alt_rd),
    .rdata_o(rdata), .outcome_o(oc), .trap_lvl_o(tl), .trap_class_o(cls),
    .mem_addr_o(maddr), .mem_we_o(mwe), .mem_wdata_o(mem_wd),
    .alt_we_o(awe), .alt_wdata_o(alt_wd)
  );

  typedef struct packed {
    logic [1:0] lvl; logic al; logic wr; logic [2:0] nv;
    logic host; logic l2en; logic l3p; logic l264; logic l3cap; logic l2cap;
    logic fgr; logic fgw; logic l3fg; logic halt; logic sdd; logic prio;
    logic [2:0] oc; logic [1:0] tl; logic [3:0] req;
  } vec_t;

  // fields: lvl al wr nv | host l2en l3p l264 l3cap l2cap fgr fgw l3fg halt sdd prio | oc tl req
  localparam int NVEC = 26;
  localparam vec_t VT [NVEC] = '{
    '{2'd0,O,O,3'b000, O,O,O,O,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd1}, // R1
    '{2'd0,I,I,3'b111, I,I,I,I,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd1}, // R1
    '{2'd1,O,O,3'b000, O,I,I,O,I,I,O,O,O,I,I,I, 3'd1,2'd0,4'd2}, // R2 undef first
    '{2'd1,O,O,3'b000, O,I,I,O,I,I,O,O,O,I,I,O, 3'd2,2'd2,4'd2}, // R2 l2 trap
    '{2'd1,O,O,3'b000, O,I,O,O,O,O,I,O,O,O,O,O, 3'd2,2'd2,4'd2}, // R2 fine-grained read
    '{2'd1,O,O,3'b000, O,I,I,O,I,O,I,O,O,O,O,O, 3'd2,2'd3,4'd2}, // R2 fg blocked, l3 trap
    '{2'd1,O,I,3'b000, O,I,I,O,O,O,I,O,I,O,O,O, 3'd0,2'd0,4'd2}, // R2 write ignores read trap
    '{2'd1,O,O,3'b000, O,O,I,O,I,O,O,O,O,I,I,O, 3'd1,2'd0,4'd2}, // R2 halted l3 undef
    '{2'd1,O,O,3'b111, O,I,O,O,O,O,O,O,O,O,O,O, 3'd3,2'd0,4'd3}, // R3
    '{2'd1,O,O,3'b111, O,O,O,O,O,O,O,O,O,O,O,O, 3'd0,2'd0,4'd3}, // R3 l2 disabled
    '{2'd1,O,I,3'b111, O,I,O,O,O,O,O,I,O,O,O,O, 3'd2,2'd2,4'd2}, // R2 fg write beats redirect
    '{2'd2,O,O,3'b000, I,O,O,O,O,O,O,O,O,O,O,O, 3'd4,2'd0,4'd4}, // R4
    '{2'd2,O,O,3'b000, I,O,I,O,I,O,O,O,O,O,O,O, 3'd2,2'd3,4'd4}, // R4 l3 trap first
    '{2'd2,O,O,3'b000, O,O,O,O,O,O,O,O,O,O,O,O, 3'd0,2'd0,4'd4}, // R4
    '{2'd1,I,O,3'b101, O,I,O,O,O,O,O,O,O,O,O,O, 3'd3,2'd0,4'd5}, // R5
    '{2'd1,I,O,3'b001, O,I,O,O,O,O,O,O,O,O,O,O, 3'd2,2'd2,4'd5}, // R5
    '{2'd1,I,O,3'b111, O,I,O,O,O,O,O,O,O,O,O,O, 3'd2,2'd2,4'd5}, // R5
    '{2'd1,I,O,3'b000, O,I,O,O,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd5}, // R5
    '{2'd1,I,O,3'b101, O,O,O,O,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd5}, // R5
    '{2'd2,I,O,3'b000, O,I,O,O,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd6}, // R6
    '{2'd2,I,O,3'b000, I,O,O,O,O,O,O,O,O,O,O,O, 3'd0,2'd0,4'd6}, // R6
    '{2'd2,I,O,3'b000, I,O,I,O,I,O,O,O,O,I,I,O, 3'd1,2'd0,4'd6}, // R6
    '{2'd3,I,O,3'b000, I,I,O,I,O,O,O,O,O,O,O,O, 3'd0,2'd0,4'd7}, // R7
    '{2'd3,I,O,3'b000, I,I,O,O,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd7}, // R7
    '{2'd3,I,O,3'b000, O,I,O,I,O,O,O,O,O,O,O,O, 3'd1,2'd0,4'd7}, // R7
    '{2'd3,O,O,3'b111, I,I,I,I,I,I,I,I,I,I,I,I, 3'd0,2'd0,4'd8}  // R8
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    valid = 1'b0; lvl = 2'd0; alias_s = 1'b0; wr = 1'b0; wdata = '0; nv = 3'd0;
    halt = 1'b0; sdd = 1'b0; prio = 1'b0; l3p = 1'b0; l3cap = 1'b0; l3fg = 1'b0;
    l2en = 1'b0; l264 = 1'b0; host = 1'b0; l2cap = 1'b0; fgr = 1'b0; fgw = 1'b0;
  endtask

  // direct level-3 read of the held register
  task automatic read_reg(input string req, input logic [63:0] exp);
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd3;
    #1 chk(rdata == exp && oc == 3'd0, req, rdata, exp);
  endtask

  task automatic write_l3(input logic [63:0] d);
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd3; wr = 1'b1; wdata = d;
  endtask

  initial begin
    quiet(); mem_rd = 64'h0; alt_rd = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_reg("R12 reset value", 64'h0);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      quiet(); valid = 1'b1;
      lvl = VT[k].lvl; alias_s = VT[k].al; wr = VT[k].wr; nv = VT[k].nv;
      host = VT[k].host; l2en = VT[k].l2en; l3p = VT[k].l3p; l264 = VT[k].l264;
      l3cap = VT[k].l3cap; l2cap = VT[k].l2cap; fgr = VT[k].fgr; fgw = VT[k].fgw;
      l3fg = VT[k].l3fg; halt = VT[k].halt; sdd = VT[k].sdd; prio = VT[k].prio;
      #1;
      chk(oc == VT[k].oc, $sformatf("R%0d outcome vec %0d", VT[k].req, k), 64'(oc), 64'(VT[k].oc));
      chk(tl == VT[k].tl, $sformatf("R%0d trap level vec %0d", VT[k].req, k), 64'(tl), 64'(VT[k].tl));
      // R9 class code tied to trap outcome
      chk(cls == ((VT[k].oc == 3'd2) ? 6'h18 : 6'h0), "R9 trap class", 64'(cls),
          64'((VT[k].oc == 3'd2) ? 6'h18 : 6'h0));
    end

    // R10: only writable fields stick
    write_l3(64'hFFFF_FFFF_FFFF_FFFF);
    read_reg("R10 all-ones write", MASK);

    // R11: trapped write leaves register alone
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd1; wr = 1'b1; wdata = 64'h0; l2en = 1'b1; l2cap = 1'b1;
    #1 chk(oc == 3'd2 && tl == 2'd2 && cls == 6'h18, "R9 trap on write", 64'(oc), 64'd2);
    read_reg("R11 after trap", MASK);

    // R11: undefined write leaves register alone
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd0; wr = 1'b1; wdata = 64'h0;
    read_reg("R11 after undefined", MASK);

    // R3: memory redirect on write
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd1; wr = 1'b1; wdata = 64'h0000_0000_0000_AAAA;
    l2en = 1'b1; nv = 3'b111;
    #1 chk(mwe && !awe && mem_wd == 64'hAAAA && maddr == 12'h100, "R3 mem write", {mwe, maddr}, {1'b1, 12'h100});
    read_reg("R11 after mem redirect", MASK);

    // R3: memory redirect on read
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd1; l2en = 1'b1; nv = 3'b111; mem_rd = 64'h1234_5678_9ABC_DEF0;
    #1 chk(rdata == 64'h1234_5678_9ABC_DEF0 && !mwe, "R3 mem read", rdata, 64'h1234_5678_9ABC_DEF0);

    // R4: alternate register redirect
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd2; host = 1'b1; wr = 1'b1; wdata = 64'h55;
    #1 chk(awe && !mwe && alt_wd == 64'h55, "R4 alt write", {63'd0, awe}, 64'd1);
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd2; host = 1'b1; alt_rd = 64'h77;
    #1 chk(rdata == 64'h77, "R4 alt read", rdata, 64'h77);
    read_reg("R11 after alt redirect", MASK);

    // R10: field positions, bit 28 cleared
    @(negedge clk);
    quiet(); valid = 1'b1; lvl = 2'd1; wr = 1'b1; wdata = 64'hFFFF_FFFF_EFFF_FFFF;
    read_reg("R10 trace bit clear", 64'h0000_0000_0033_0000);
    write_l3(64'h0000_0000_0020_0000);
    read_reg("R10 fp field only", 64'h0000_0000_0020_0000);

    // R11: write without valid ignored
    @(negedge clk);
    quiet(); lvl = 2'd3; wr = 1'b1; wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    read_reg("R11 invalid write", 64'h0000_0000_0020_0000);

    // R12: reset mid-run clears the register
    write_l3(64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    quiet(); rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_reg("R12 reset clears", 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule